// File: doc/BRIEF.md
# Floppy Controller Host Register Block with Reset Control

This block is the host-facing register front end of a floppy disk controller. It holds the drive-control byte, the data-rate select register, a small tape register and the write path into the command FIFO. It also returns the main status byte. Reset control for the controller core rests on a single place: the active-low reset bit inside the stored drive-control byte. Every decision about whether the controller is in reset reads that bit.

A host reaches the block over a byte-wide register bus. Each cycle carries an address, a read strobe, a write strobe and write data. Read data is registered. The block drives the motor-enable lines, the DMA-enable line and the selected drive number straight from the stored drive-control byte. The controller core receives a one-clock reset pulse, and an interrupt line stays high until the core acknowledges it. The command FIFO, the drive mechanics and the DMA engine are outside this block. The FIFO gets a one-clock push strobe with its data byte, and the core's busy state comes back in only through the main status byte.

The controller leaves reset when a drive-control write moves the reset bit from 0 to 1, or when the host reads the main status byte. A software reset requested through the data-rate register puts the controller back in its reset state and clears itself.

Top module: `fdc_host_regs`

## Requirements
- R1: After the synchronous `rst`, the drive-control byte is 0x04 with bit 3 also set when `HAS_DMA` is 1. `irq`, `irq_status`, `ctl_reset_pulse`, `sleep`, `fifo_push`, `rate_sel` and the tape register are all 0.
- R2: A read at offset 2 returns the stored drive-control byte unchanged. Its fields are: drive select in bits 1:0, active-low reset in bit 2, DMA enable in bit 3 and motor enables in bits 7:4. Read data appears on `bus_rdata` one clock after the read strobe.
- R3: A write at offset 2 is always stored, even while bit 2 is 0. From the next clock, `motor_en`, `dma_en` and `drive_sel` equal bits 7:4, bit 3 and bits 1:0 of the written byte.
- R4: A write at offset 2 with bit 2 set, while the stored bit 2 is 0, raises `ctl_reset_pulse` for exactly one clock. In the same clock it raises `irq` with `irq_status` = 0xC0, clears `sleep` and clears the tape register. The stored byte is the written value. A write that leaves bit 2 at 1, or that clears it, gives no pulse.
- R5: While stored bit 2 is 0, writes at offsets 3 (tape, bits 1:0, readable at offset 3), 4 (data rate) and 5 (FIFO) have no effect. When bit 2 is 1, a write at offset 5 gives one `fifo_push` clock with `fifo_wdata` equal to the written byte.
- R6: A read at offset 4 sets stored bit 2 to 1 and clears `sleep`, without a reset pulse and without an interrupt.
- R7: The byte read at offset 4 has bit 7 = NOT `busy_in`, bit 4 = `busy_in`, and every other bit 0.
- R8: A permitted write at offset 4 with bit 7 set reloads the R1 default into the drive-control byte (bit 2 stays 1). It also pulses `ctl_reset_pulse` for one clock and raises `irq` with 0xC0.
- R9: A permitted write at offset 4 stores bits 1:0 into `rate_sel`. Bit 6 set in that write sets `sleep`, and this takes priority over a software reset in the same write.
- R10: `irq` stays high until `irq_ack` is sampled high, then falls, and `irq_status` becomes 0. A new raise in the same clock as an acknowledge wins.
- R11: Reads at offsets 0, 1, 5, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| busy_in | input | 1 | Controller core busy |
| irq_ack | input | 1 | Sense-interrupt acknowledge |
| ctl_reset_pulse | output | 1 | One-clock internal reset to the core |
| irq | output | 1 | Interrupt request |
| irq_status | output | 8 | Status code of the pending interrupt |
| motor_en | output | 4 | Motor enables |
| dma_en | output | 1 | DMA enable |
| drive_sel | output | 2 | Selected drive |
| sleep | output | 1 | Power-down flag |
| rate_sel | output | 2 | Data-rate select |
| fifo_push | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write byte |

## Verification
The embedded assertions check, on every clock, several one-step rules:
- a drive-control write lands in the stored byte;
- a status read leaves the reset bit at 1;
- gated tape writes leave the tape register unchanged;
- a power-down write sets `sleep`;
- the interrupt holds until acknowledged;
- every reset pulse comes with a 0xC0 interrupt;
- the status byte's ready bit tracks `busy_in`.

Other properties depend on the history of the stored reset bit, so only the bench scenarios show them. One is that a pulse appears exactly on 0-to-1 transitions, which the bench checks by sweeping all 256 drive-control values in sequence. Others are the blocking of gated writes until a status read, the default reload after a software reset, and the zero reads at unmapped offsets.

// File: rtl/fdc_regs_pkg.sv
package fdc_regs_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_DCTL = 3'd2;
  localparam logic [OFS_W-1:0] OFS_TAPE = 3'd3;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd4;
  localparam logic [OFS_W-1:0] OFS_FIFO = 3'd5;

  localparam int DCTL_NRST_BIT = 2;
  localparam int DCTL_DMA_BIT  = 3;
  localparam int DCTL_MOT_LSB  = 4;

  localparam int RATE_SWRST_BIT = 7;
  localparam int RATE_PWRDN_BIT = 6;

  localparam int STAT_RQM_BIT  = 7;
  localparam int STAT_BUSY_BIT = 4;

  localparam logic [BYTE_W-1:0] CODE_READY_CHG = 8'hC0;

  function automatic logic [BYTE_W-1:0] dctl_default(input bit has_dma);
    logic [BYTE_W-1:0] v;
    v = '0;
    v[DCTL_NRST_BIT] = 1'b1;
    v[DCTL_DMA_BIT]  = has_dma;
    return v;
  endfunction
endpackage

// File: rtl/fdc_dctl_reg.sv
module fdc_dctl_reg
  import fdc_regs_pkg::*;
#(
  parameter bit HAS_DMA = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_dctl,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              stat_rd,
  input  logic              sw_reset,
  output logic [BYTE_W-1:0] dctl_q,
  output logic              exit_req
);
  localparam logic [BYTE_W-1:0] DEFAULT_V = dctl_default(HAS_DMA);

  assign exit_req = wr_dctl && !dctl_q[DCTL_NRST_BIT] && wdata[DCTL_NRST_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      dctl_q <= DEFAULT_V;
    end else if (wr_dctl) begin
      dctl_q <= wdata;
    end else if (sw_reset) begin
      dctl_q <= DEFAULT_V;
    end else if (stat_rd) begin
      dctl_q[DCTL_NRST_BIT] <= 1'b1;
    end
  end

  AST_DCTL_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    wr_dctl |=> dctl_q == $past(wdata)); // R3

  AST_STAT_READ_EXITS: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !wr_dctl) |=> dctl_q[DCTL_NRST_BIT]); // R6
endmodule

// File: rtl/fdc_aux_regs.sv
module fdc_aux_regs
  import fdc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              nrst_bit,
  input  logic              wr_tape,
  input  logic              wr_rate,
  input  logic              wr_fifo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              stat_rd,
  input  logic              int_reset,
  output logic              sw_reset_req,
  output logic [1:0]        tape_q,
  output logic [1:0]        rate_q,
  output logic              sleep_q,
  output logic              fifo_push_q,
  output logic [BYTE_W-1:0] fifo_data_q
);
  logic tape_ok, rate_ok, fifo_ok;

  assign tape_ok      = wr_tape && nrst_bit;
  assign rate_ok      = wr_rate && nrst_bit;
  assign fifo_ok      = wr_fifo && nrst_bit;
  assign sw_reset_req = rate_ok && wdata[RATE_SWRST_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      tape_q      <= '0;
      rate_q      <= '0;
      sleep_q     <= 1'b0;
      fifo_push_q <= 1'b0;
      fifo_data_q <= '0;
    end else begin
      if (tape_ok)        tape_q <= wdata[1:0];
      else if (int_reset) tape_q <= '0;

      if (rate_ok) rate_q <= wdata[1:0];

      if (rate_ok && wdata[RATE_PWRDN_BIT]) sleep_q <= 1'b1;
      else if (int_reset || stat_rd)        sleep_q <= 1'b0;

      fifo_push_q <= fifo_ok;
      if (fifo_ok) fifo_data_q <= wdata;
    end
  end

  AST_GATED_TAPE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr_tape && !nrst_bit) |=> $stable(tape_q)); // R5

  AST_PWRDN_SETS_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_rate && nrst_bit && wdata[RATE_PWRDN_BIT]) |=> sleep_q); // R9
endmodule

// File: rtl/fdc_irq_ctrl.sv
module fdc_irq_ctrl
  import fdc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              raise,
  input  logic              ack,
  output logic              pulse_q,
  output logic              irq_q,
  output logic [BYTE_W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      irq_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      pulse_q <= raise;
      if (raise) begin
        irq_q  <= 1'b1;
        code_q <= CODE_READY_CHG;
      end else if (ack) begin
        irq_q  <= 1'b0;
        code_q <= '0;
      end
    end
  end

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !ack) |=> irq_q); // R10

  AST_PULSE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> (irq_q && code_q == CODE_READY_CHG)); // R4
endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
  import fdc_regs_pkg::*;
#(
  parameter bit HAS_DMA = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        busy_in,
  input  logic        irq_ack,
  output logic        ctl_reset_pulse,
  output logic        irq,
  output logic [7:0]  irq_status,
  output logic [3:0]  motor_en,
  output logic        dma_en,
  output logic [1:0]  drive_sel,
  output logic        sleep,
  output logic [1:0]  rate_sel,
  output logic        fifo_push,
  output logic [7:0]  fifo_wdata
);
  logic              wr_dctl, wr_tape, wr_rate, wr_fifo, stat_rd;
  logic              exit_req, sw_reset_req, int_reset;
  logic [BYTE_W-1:0] dctl_q;
  logic [1:0]        tape_q;
  logic [BYTE_W-1:0] stat_byte;

  assign wr_dctl   = bus_wr && (bus_addr == OFS_DCTL);
  assign wr_tape   = bus_wr && (bus_addr == OFS_TAPE);
  assign wr_rate   = bus_wr && (bus_addr == OFS_STAT);
  assign wr_fifo   = bus_wr && (bus_addr == OFS_FIFO);
  assign stat_rd   = bus_rd && (bus_addr == OFS_STAT);
  assign int_reset = exit_req || sw_reset_req;

  fdc_dctl_reg #(.HAS_DMA(HAS_DMA)) u_dctl (
    .clk      (clk),
    .rst      (rst),
    .wr_dctl  (wr_dctl),
    .wdata    (bus_wdata),
    .stat_rd  (stat_rd),
    .sw_reset (sw_reset_req),
    .dctl_q   (dctl_q),
    .exit_req (exit_req)
  );

  fdc_aux_regs u_aux (
    .clk          (clk),
    .rst          (rst),
    .nrst_bit     (dctl_q[DCTL_NRST_BIT]),
    .wr_tape      (wr_tape),
    .wr_rate      (wr_rate),
    .wr_fifo      (wr_fifo),
    .wdata        (bus_wdata),
    .stat_rd      (stat_rd),
    .int_reset    (int_reset),
    .sw_reset_req (sw_reset_req),
    .tape_q       (tape_q),
    .rate_q       (rate_sel),
    .sleep_q      (sleep),
    .fifo_push_q  (fifo_push),
    .fifo_data_q  (fifo_wdata)
  );

  fdc_irq_ctrl u_irq (
    .clk     (clk),
    .rst     (rst),
    .raise   (int_reset),
    .ack     (irq_ack),
    .pulse_q (ctl_reset_pulse),
    .irq_q   (irq),
    .code_q  (irq_status)
  );

  always_comb begin
    stat_byte = '0;
    stat_byte[STAT_RQM_BIT]  = !busy_in;
    stat_byte[STAT_BUSY_BIT] = busy_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_DCTL: bus_rdata <= dctl_q;
        OFS_TAPE: bus_rdata <= {6'b0, tape_q};
        OFS_STAT: bus_rdata <= stat_byte;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign motor_en  = dctl_q[DCTL_MOT_LSB +: 4];
  assign dma_en    = dctl_q[DCTL_DMA_BIT];
  assign drive_sel = dctl_q[1:0];

  AST_STAT_READY_TRACKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> bus_rdata[STAT_RQM_BIT] == !$past(busy_in)); // R7
endmodule

// File: tb/fdc_host_regs_tb.sv
module fdc_host_regs_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       busy_in = 1'b0, irq_ack = 1'b0;
  logic       ctl_reset_pulse, irq, dma_en, sleep, fifo_push;
  logic [7:0] irq_status, fifo_wdata;
  logic [3:0] motor_en;
  logic [1:0] drive_sel, rate_sel;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_dctl;

  always #10 clk = ~clk;

  fdc_host_regs #(.HAS_DMA(1'b1)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy_in(busy_in), .irq_ack(irq_ack),
    .ctl_reset_pulse(ctl_reset_pulse), .irq(irq), .irq_status(irq_status),
    .motor_en(motor_en), .dma_en(dma_en), .drive_sel(drive_sel), .sleep(sleep),
    .rate_sel(rate_sel), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ack_irq();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 dctl outputs", {motor_en, dma_en, drive_sel}, 7'b0000_1_00);
    check("R1 irq/pulse/sleep/push", {irq, ctl_reset_pulse, sleep, fifo_push}, 4'b0);
    check("R1 irq_status/rate", {irq_status, rate_sel}, 10'b0);
    bus_read(3'd2);
    check("R2 default read", bus_rdata, 8'h0C);
    m_dctl = 8'h0C;

    // R2 R3 R4 sweep of all drive-control values in sequence
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vb;
      logic       exp_p;
      vb = v[7:0];
      exp_p = !m_dctl[2] && vb[2];
      bus_write(3'd2, vb);
      m_dctl = vb;
      check("R3 outputs follow write", {motor_en, dma_en, drive_sel}, {vb[7:4], vb[3], vb[1:0]});
      check("R4 pulse on exit edge", ctl_reset_pulse, exp_p);
      if (exp_p) begin
        check("R4 irq with code", {irq, irq_status}, {1'b1, 8'hC0});
        repeat (2) @(negedge clk);
        check("R10 irq holds", irq, 1'b1);
        check("R4 pulse one clock", ctl_reset_pulse, 1'b0);
        ack_irq();
        check("R10 ack clears", {irq, irq_status}, 9'b0);
      end else begin
        check("R4 no irq without exit", irq, 1'b0);
      end
      bus_read(3'd2);
      check("R2 readback", bus_rdata, vb);
    end

    // R5 gating while reset bit is 0
    bus_write(3'd2, 8'h31);
    bus_write(3'd3, 8'h03);
    bus_read(3'd3);
    check("R5 tape blocked", bus_rdata, 8'h00);
    bus_write(3'd4, 8'hC3);
    check("R5 rate write blocked", {sleep, rate_sel, ctl_reset_pulse, irq}, 5'b0);
    bus_write(3'd5, 8'hA5);
    check("R5 fifo blocked", fifo_push, 1'b0);
    bus_read(3'd2);
    check("R5 dctl unchanged", bus_rdata, 8'h31);

    // R6 status read leaves reset
    bus_read(3'd4);
    check("R6 no pulse/irq", {ctl_reset_pulse, irq}, 2'b00);
    bus_read(3'd2);
    check("R6 reset bit set", bus_rdata, 8'h35);

    // R5 permitted writes
    bus_write(3'd3, 8'h02);
    bus_read(3'd3);
    check("R5 tape stored", bus_rdata, 8'h02);
    bus_write(3'd5, 8'h5A);
    check("R5 fifo push", {fifo_push, fifo_wdata}, {1'b1, 8'h5A});
    @(negedge clk);
    check("R5 push one clock", fifo_push, 1'b0);

    // R9 rate and power-down
    for (int r = 0; r < 4; r++) begin
      bus_write(3'd4, r[7:0]);
      check("R9 rate stored", rate_sel, r[1:0]);
      check("R9 no sleep", sleep, 1'b0);
    end
    bus_write(3'd4, 8'h41);
    check("R9 power-down sets sleep", {sleep, rate_sel}, 3'b1_01);
    bus_read(3'd4);
    check("R6 status read clears sleep", sleep, 1'b0);

    // R7 status byte against busy
    for (int b = 0; b < 2; b++) begin
      busy_in = b[0];
      bus_read(3'd4);
      check("R7 status byte", bus_rdata, {~b[0], 2'b00, b[0], 4'b0000});
    end
    busy_in = 1'b0;

    // R8 software reset
    bus_write(3'd2, 8'hF6);
    bus_write(3'd4, 8'h80);
    check("R8 pulse and irq", {ctl_reset_pulse, irq, irq_status}, {2'b11, 8'hC0});
    check("R8 defaults reloaded", {motor_en, dma_en, drive_sel}, 7'b0000_1_00);
    bus_read(3'd2);
    check("R8 dctl readback", bus_rdata, 8'h0C);
    bus_read(3'd3);
    check("R4 tape cleared by internal reset", bus_rdata, 8'h00);
    ack_irq();
    check("R10 ack", irq, 1'b0);

    // R9 power-down beats software reset
    bus_write(3'd4, 8'hC2);
    check("R9 sleep over swreset", {sleep, rate_sel, ctl_reset_pulse}, 4'b1_10_1);
    ack_irq();

    // R11 unmapped reads
    for (int a = 0; a < 8; a++) begin
      if (a == 0 || a == 1 || a >= 5) begin
        bus_read(a[2:0]);
        check("R11 unmapped zero", bus_rdata, 8'h00);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule